// File: doc/BRIEF.md
# Floating-Point Operand Denormal Pre-Conditioner

This block sits in front of a floating-point arithmetic datapath and conditions up to three source operands (A, B and C) in one pass. Every operand arrives as a 64-bit double-format word, together with one flag that says whether the operation runs at single or double precision. The block sorts each operand into one of five classes: normal-or-zero, single-range denormal, double denormal, quiet NaN or signaling NaN. It then hands the datapath a sign, a widened exponent and a mantissa that carries an explicit hidden bit.

A mode input selects the treatment of denormals. With the mode clear, a denormal is normalized. Its fraction is shifted left until the hidden bit is one, and the exponent, which is two bits wider than the format's and signed, drops below the smallest normal value. With the mode set, a denormal is replaced by a zero that keeps its sign, so the datapath never sees a denormal value and needs no variable-latency path for one. Each operand is treated on its own. Whenever any operand is a NaN, denormal treatment is bypassed for all three operands, and a NaN-present flag tells the downstream logic to produce a quiet NaN. A separate flag reports a signaling NaN, for use in invalid-operation reporting. The result appears one cycle after the input, qualified by a valid bit.

Top module: `fp_denorm_prep`

## Requirements
- R1: Each operand output carries a one-hot class vector `cls_o[i]`: bit 0 normal-or-zero (this class also takes infinities), bit 1 single-range denormal, bit 2 double denormal, bit 3 quiet NaN (exponent all ones, fraction MSB 1), bit 4 signaling NaN (exponent all ones, fraction MSB 0, fraction nonzero). Index 0 is A, 1 is B, 2 is C.
- R2: A double denormal has a zero exponent field and a nonzero fraction, whatever the precision. A single-range denormal needs `single_i`=1 and a biased exponent from 1 to 896. With `single_i`=0, or with an exponent of 897 or more, the operand is normal.
- R3: With `non_ieee_i`=0 and no NaN present, a double denormal whose highest set fraction bit is at position p (0..51) leaves with mantissa `{1'b0,frac} << (52-p)` (bit 52 set) and a signed 13-bit exponent p-51. A single-range denormal leaves as `{1, frac}` with its exponent zero-extended.
- R4: With `non_ieee_i`=1 and no NaN present, every denormal (single-range or double) leaves as exponent 0 and mantissa 0, and keeps its original sign.
- R5: A normal, zero or infinite operand leaves as exponent `{2'b00, e}` and mantissa `{e!=0, frac}`, in either mode.
- R6: The operands are handled independently. Any subset of the three may be normalized or flushed in the same cycle.
- R7: If any operand is a NaN, `nan_o`=1 and all three operands leave in the raw form of R5, with denormals left untouched. `snan_o`=1 exactly when at least one operand is a signaling NaN.
- R8: `out_valid_o` follows `in_valid_i` with a latency of one cycle, and each valid input produces exactly one result.
- R9: After reset, `out_valid_o` and every data output are 0.
- R10: In non-IEEE mode with no NaN present, no output has a nonzero mantissa with an exponent at or below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set valid |
| single_i | input | 1 | Operation is single precision |
| non_ieee_i | input | 1 | 1: flush denormals to zero; 0: normalize them |
| opa_i | input | 64 | Operand A, double format |
| opb_i | input | 64 | Operand B, double format |
| opc_i | input | 64 | Operand C, double format |
| out_valid_o | output | 1 | Result valid |
| sign_o | output | 3 | Sign per operand |
| exp_o | output | 3x13 | Widened signed biased exponent per operand |
| mant_o | output | 3x53 | Mantissa with explicit hidden bit per operand |
| cls_o | output | 3x5 | One-hot class per operand |
| nan_o | output | 1 | At least one operand is a NaN |
| snan_o | output | 1 | At least one operand is a signaling NaN |

## Verification
Two kinds of event can fall in the same cycle: a denormal being normalized or flushed in one lane, and a NaN in another lane that must override that treatment. The bench provokes the overlap by sending vectors where a quiet or signaling NaN shares the set with single-range and double denormals in both modes. It also sends sets in which all three lanes, or any two of them, are denormal at once, which confirms that the lanes are independent. Each result is judged against a model built from the requirements, field by field, in the cycle after the input.

// File: rtl/fp_denorm_prep.sv
module fp_denorm_prep #(
  parameter int EXP_W           = 11,
  parameter int FRAC_W          = 52,
  parameter int SGL_EMIN_BIASED = 897
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid_i,
  input  logic                                    single_i,
  input  logic                                    non_ieee_i,
  input  logic [EXP_W+FRAC_W:0]                   opa_i,
  input  logic [EXP_W+FRAC_W:0]                   opb_i,
  input  logic [EXP_W+FRAC_W:0]                   opc_i,
  output logic                                    out_valid_o,
  output logic [2:0]                              sign_o,
  output logic [2:0][EXP_W+1:0]                   exp_o,
  output logic [2:0][FRAC_W:0]                    mant_o,
  output logic [2:0][4:0]                         cls_o,
  output logic                                    nan_o,
  output logic                                    snan_o
);

  localparam int NOPS   = 3;
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int XEXP_W = EXP_W + 2;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int LZ_W   = $clog2(FRAC_W + 1);
  localparam logic [EXP_W-1:0] SGL_EMIN = EXP_W'(SGL_EMIN_BIASED);

  function automatic logic [LZ_W-1:0] lzc(input logic [FRAC_W-1:0] f);
    lzc = LZ_W'(FRAC_W);
    for (int k = 0; k < FRAC_W; k++)
      if (f[k]) lzc = LZ_W'(FRAC_W - 1 - k);
  endfunction

  logic [NOPS-1:0][W-1:0]      ops;
  logic [NOPS-1:0]             nan_v, snan_v;
  logic [NOPS-1:0]             sign_d;
  logic [NOPS-1:0][XEXP_W-1:0] exp_d;
  logic [NOPS-1:0][SIG_W-1:0]  mant_d;
  logic [NOPS-1:0][4:0]        cls_d;
  logic                        nan_any, snan_any;

  assign ops      = {opc_i, opb_i, opa_i};
  assign nan_any  = |nan_v;
  assign snan_any = |snan_v;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    logic              s;
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    logic              qn, sn, dd, sd, nz;
    logic [LZ_W-1:0]   lz;

    assign {s, e, f} = ops[i];
    assign qn = (&e) & f[FRAC_W-1];
    assign sn = (&e) & ~f[FRAC_W-1] & (|f);
    assign dd = ~(|e) & (|f);
    assign sd = single_i & (|e) & (e < SGL_EMIN);
    assign nz = ~(qn | sn | dd | sd);
    assign lz = lzc(f);

    assign nan_v[i]  = qn | sn;
    assign snan_v[i] = sn;
    assign cls_d[i]  = {sn, qn, dd, sd, nz};

    always_comb begin
      sign_d[i] = s;
      exp_d[i]  = {2'b00, e};
      mant_d[i] = {|e, f};
      if (!nan_any && (dd || sd)) begin
        if (non_ieee_i) begin
          exp_d[i]  = '0;
          mant_d[i] = '0;
        end else if (dd) begin
          exp_d[i]  = XEXP_W'(0) - XEXP_W'(lz);
          mant_d[i] = {1'b0, f} << (lz + 1'b1);
        end
      end
    end

    assert_cls_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $countones(cls_o[i]) == 1);

    assert_hidden_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !nan_o) |-> (mant_o[i] == '0 || mant_o[i][SIG_W-1]));

    assert_flush_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && $past(non_ieee_i) && !nan_o && (cls_o[i][2:1] != 2'b00))
        |-> (mant_o[i] == '0 && exp_o[i] == '0 && sign_o[i] == $past(ops[i][W-1])));

    assert_no_denorm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && $past(non_ieee_i) && !nan_o)
        |-> (mant_o[i] == '0 || (!exp_o[i][XEXP_W-1] && exp_o[i] != '0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      sign_o      <= '0;
      exp_o       <= '0;
      mant_o      <= '0;
      cls_o       <= '0;
      nan_o       <= 1'b0;
      snan_o      <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sign_o <= sign_d;
        exp_o  <= exp_d;
        mant_o <= mant_d;
        cls_o  <= cls_d;
        nan_o  <= nan_any;
        snan_o <= snan_any;
      end
    end
  end

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);

  assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);

  assert_snan_in_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snan_o |-> nan_o);

endmodule

// File: tb/fp_denorm_prep_tb.sv
module fp_denorm_prep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 3 + 3*13 + 3*53 + 3*5 + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid_i = 1'b0, single_i = 1'b0, non_ieee_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0, opc_i = '0;
  logic out_valid_o;
  logic [2:0] sign_o;
  logic [2:0][12:0] exp_o;
  logic [2:0][52:0] mant_o;
  logic [2:0][4:0] cls_o;
  logic nan_o, snan_o;

  int checks = 0;
  int fails  = 0;
  logic [RW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_denorm_prep u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .single_i(single_i),
    .non_ieee_i(non_ieee_i), .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i),
    .out_valid_o(out_valid_o), .sign_o(sign_o), .exp_o(exp_o), .mant_o(mant_o),
    .cls_o(cls_o), .nan_o(nan_o), .snan_o(snan_o));

  function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
    return {s, 11'(e), f};
  endfunction

  function automatic logic [RW-1:0] model(input logic [63:0] a, b, c,
                                          input logic sg, ni);
    logic [2:0][63:0] v;
    logic [2:0] s;
    logic [2:0][12:0] ex;
    logic [2:0][52:0] mn;
    logic [2:0][4:0] cl;
    logic anynan, anysnan;
    v = {c, b, a};
    anynan = 1'b0; anysnan = 1'b0;
    for (int i = 0; i < 3; i++) begin
      logic [10:0] e;
      logic [51:0] f;
      e = v[i][62:52]; f = v[i][51:0];
      if (e == 11'h7ff && f[51])            cl[i] = 5'b01000;
      else if (e == 11'h7ff && f != 0)      cl[i] = 5'b10000;
      else if (e == 0 && f != 0)            cl[i] = 5'b00100;
      else if (sg && e != 0 && e <= 896)    cl[i] = 5'b00010;
      else                                  cl[i] = 5'b00001;
      if (cl[i][3] || cl[i][4]) anynan = 1'b1;
      if (cl[i][4]) anysnan = 1'b1;
    end
    for (int i = 0; i < 3; i++) begin
      logic [10:0] e;
      logic [51:0] f;
      e = v[i][62:52]; f = v[i][51:0];
      s[i]  = v[i][63];
      ex[i] = {2'b00, e};
      mn[i] = {e != 0, f};
      if (!anynan && (cl[i][1] || cl[i][2])) begin
        if (ni) begin
          ex[i] = '0; mn[i] = '0;
        end else if (cl[i][2]) begin
          int p;
          p = 0;
          for (int k = 0; k < 52; k++) if (f[k]) p = k;
          mn[i] = {1'b0, f} << (52 - p);
          ex[i] = 13'(p - 51);
        end
      end
    end
    return {s, ex, mn, cl, anynan, anysnan};
  endfunction

  task automatic apply(input logic [63:0] a, b, c, input logic sg, ni, input string tag);
    @(negedge clk);
    in_valid_i = 1'b1; single_i = sg; non_ieee_i = ni;
    opa_i = a; opb_i = b; opc_i = c;
    exp_q.push_back(model(a, b, c, sg, ni));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid_i = 1'b0;
      opa_i = {$urandom, $urandom}; opb_i = {$urandom, $urandom};
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      logic [RW-1:0] got, want;
      string t;
      got = {sign_o, exp_o, mant_o, cls_o, nan_o, snan_o};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected result got %h expected none", got);
      end else begin
        want = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== want) begin
          fails++;
          $display("FAIL %s got %h expected %h", t, got, want);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] one, neg_norm, zero_n, inf_p, qn, sn;
    logic [63:0] dd_top, dd_low, dd_mid, sd_lo, sd_hi, e896, e897;
    one      = mk(0, 1023, 52'h0);
    neg_norm = mk(1, 1500, 52'h1234_5678_9abc);
    zero_n   = mk(1, 0, 52'h0);
    inf_p    = mk(0, 2047, 52'h0);
    qn       = mk(0, 2047, 52'h8_0000_0000_0001);
    sn       = mk(1, 2047, 52'h0_0000_0000_0001);
    dd_top   = mk(0, 0, 52'h8_0000_0000_0000);
    dd_low   = mk(1, 0, 52'h0_0000_0000_0001);
    dd_mid   = mk(0, 0, 52'h0_0040_0000_abcd);
    sd_lo    = mk(1, 1, 52'h5_5555_5555_5555);
    sd_hi    = mk(0, 896, 52'hf_0000_0000_0000);
    e896     = mk(0, 896, 52'h1);
    e897     = mk(1, 897, 52'h3);

    repeat (3) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || {sign_o, exp_o, mant_o, cls_o, nan_o, snan_o} !== '0) begin
      fails++;
      $display("FAIL R9 reset outputs got %b/%h expected 0/0", out_valid_o,
               {sign_o, exp_o, mant_o, cls_o, nan_o, snan_o});
    end
    rst_n = 1'b1;
    idle(2);

    apply(one, neg_norm, zero_n, 1'b0, 1'b0, "R5 normal/zero pass");
    apply(inf_p, one, neg_norm, 1'b1, 1'b1, "R5 inf pass flush mode");
    apply(dd_top, dd_low, dd_mid, 1'b0, 1'b0, "R3 R6 normalize all three");
    apply(dd_top, dd_low, dd_mid, 1'b0, 1'b1, "R4 R6 flush all three");
    apply(sd_lo, sd_hi, one, 1'b1, 1'b0, "R2 R3 single-range pass");
    apply(sd_lo, sd_hi, one, 1'b1, 1'b1, "R2 R4 single-range flush");
    apply(e896, e897, sd_lo, 1'b0, 1'b1, "R2 double precision no single denorm");
    apply(e896, e897, one, 1'b1, 1'b1, "R2 boundary 896/897");
    idle(3);
    apply(dd_low, one, sd_lo, 1'b1, 1'b1, "R6 pair A,C flush");
    apply(one, dd_mid, sd_hi, 1'b1, 1'b0, "R6 pair B,C normalize");
    apply(zero_n, one, dd_top, 1'b0, 1'b1, "R6 single C flush");
    apply(qn, dd_low, sd_lo, 1'b1, 1'b1, "R7 qnan overrides flush");
    apply(dd_top, sn, sd_hi, 1'b1, 1'b0, "R7 snan overrides normalize");
    apply(qn, sn, one, 1'b0, 1'b0, "R1 R7 both nan kinds");
    apply(inf_p, zero_n, qn, 1'b0, 1'b1, "R1 R7 qnan only");
    idle(1);
    apply(dd_mid, dd_mid, dd_low, 1'b0, 1'b1, "R10 no denorm out");
    for (int k = 0; k < 24; k++) begin
      logic [63:0] r;
      r = mk(k[0], 0, 52'h1 << (k * 2));
      apply(r, mk(0, k * 37 + 1, 52'(k * 3)), dd_top, k[1], k[2], "R3 R4 lz sweep");
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 pending results got %0d expected 0", exp_q.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule